// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block gathers the interrupt sources of a serial port into one sticky flag register. It qualifies those flags with a software-controlled mask and drives a single level-sensitive interrupt line. Five sources are levels that the FIFOs drive continuously. Five more are single-cycle pulses from the receiver. A flag, once raised, stays up until software clears it by writing a one to it.

Software reaches the unit through a plain 32-bit word register port. The port has a byte address, a write strobe, a read strobe, write data and registered read data. The mask has no direct write path. Bits are turned on through one register and turned off through another, so several agents can adjust the mask without a read-modify-write. No data stream passes through the unit, so every pin is a plain control or status signal without valid/ready handshaking.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset the mask and the sticky flags are all zero and `irq_o` is low.
- R2: In every clock cycle where live level `live_i[k]` is high, sticky flag bit k is set (bit 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full). The flag stays set after the level falls.
- R3: A one-cycle pulse on `evt_i[k]` sets sticky flag bit 5+k (5 overrun, 6 framing error, 7 parity error, 8 receive timeout, 9 modem-status change). These flags are set by pulses only.
- R4: A write to byte offset 0x08 ORs `reg_wdata[9:0]` into the mask.
- R5: A write to byte offset 0x0C clears every mask bit whose `reg_wdata` bit is one.
- R6: A write to byte offset 0x10 (the mask) changes nothing, and a write to offset 0x2C changes nothing either.
- R7: A write to byte offset 0x14 clears every sticky flag whose `reg_wdata` bit is one.
- R8: When a set condition and a clearing write hit the same sticky bit in the same cycle, the bit ends up set.
- R9: `irq_o` is registered. It equals the OR of (mask AND sticky flags) as they stood one clock earlier.
- R10: On the clock edge where `reg_rd` is high, `reg_rdata` loads one of the following and holds it until the next read. Offset 0x10 returns the mask in bits 9:0. Offset 0x14 returns the sticky flags in bits 9:0. Offset 0x2C returns the live levels in bits 4:0. Any other offset returns zero. Bits above the defined fields always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_i | input | 5 | Live FIFO status levels |
| evt_i | input | 5 | Single-cycle receiver event pulses |
| reg_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest situation to bring about is a clearing write that lands in the very cycle a source tries to set the same flag. Ordinary stimulus never lines the two up. The bench therefore drives the clearing write and the event pulse on the same falling edge, so that one rising edge sees both. It then reads the flag back through the bus. The bench also holds a live level high across a clearing write, and checks that the flag survives.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int LIVE_N = 5;
  localparam int EVT_N  = 5;
  localparam int SRC_N  = LIVE_N + EVT_N;

  // byte offsets of the register window
  localparam int OFS_SET  = 'h08;
  localparam int OFS_CLR  = 'h0C;
  localparam int OFS_MASK = 'h10;
  localparam int OFS_FLAG = 'h14;
  localparam int OFS_LIVE = 'h2C;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_SET,
    ACC_CLR,
    ACC_MASK,
    ACC_FLAG,
    ACC_LIVE
  } acc_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_e              acc
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [1:0]        unused_byte;

  assign word        = addr[ADDR_W-1:2];
  assign unused_byte = addr[1:0];

  always_comb begin
    acc = ACC_NONE;
    if (word == WORD_W'(OFS_SET >> 2))       acc = ACC_SET;
    else if (word == WORD_W'(OFS_CLR >> 2))  acc = ACC_CLR;
    else if (word == WORD_W'(OFS_MASK >> 2)) acc = ACC_MASK;
    else if (word == WORD_W'(OFS_FLAG >> 2)) acc = ACC_FLAG;
    else if (word == WORD_W'(OFS_LIVE >> 2)) acc = ACC_LIVE;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_unit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [SRC_N-1:0] wbits,
  output logic [SRC_N-1:0] mask_q
);
  logic [SRC_N-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (set_we) mask_d = mask_q | wbits;
    if (clr_we) mask_d = mask_q & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIVE_N-1:0] live,
  input  logic [EVT_N-1:0]  evt,
  input  logic              clr_we,
  input  logic [SRC_N-1:0]  wbits,
  output logic [SRC_N-1:0]  flag_q
);
  logic [SRC_N-1:0] set_vec;
  logic [SRC_N-1:0] clr_vec;

  assign set_vec = {evt, live};
  assign clr_vec = clr_we ? wbits : '0;

  // one flop per source; setting takes precedence over clearing
  for (genvar k = 0; k < SRC_N; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[k] <= 1'b0;
      else if (set_vec[k]) flag_q[k] <= 1'b1;
      else if (clr_vec[k]) flag_q[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  acc_e              acc,
  input  logic [SRC_N-1:0]  mask,
  input  logic [SRC_N-1:0]  flag,
  input  logic [LIVE_N-1:0] live,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    unique case (acc)
      ACC_MASK: sel = DATA_W'(mask);
      ACC_FLAG: sel = DATA_W'(flag);
      ACC_LIVE: sel = DATA_W'(live);
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= sel;
  end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIVE_N-1:0] live_i,
  input  logic [EVT_N-1:0]  evt_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  acc_e             acc;
  logic [SRC_N-1:0] wbits;
  logic [SRC_N-1:0] mask_q;
  logic [SRC_N-1:0] flag_q;
  logic             unused_hi;

  assign wbits     = reg_wdata[SRC_N-1:0];
  assign unused_hi = ^reg_wdata[DATA_W-1:SRC_N];

  irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (reg_addr),
    .acc  (acc)
  );

  irq_mask_reg u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (reg_wr && acc == ACC_SET),
    .clr_we (reg_wr && acc == ACC_CLR),
    .wbits  (wbits),
    .mask_q (mask_q)
  );

  irq_flag_reg u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .live   (live_i),
    .evt    (evt_i),
    .clr_we (reg_wr && acc == ACC_FLAG),
    .wbits  (wbits),
    .flag_q (flag_q)
  );

  irq_read_mux #(.DATA_W(DATA_W)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (reg_rd),
    .acc   (acc),
    .mask  (mask_q),
    .flag  (flag_q),
    .live  (live_i),
    .rdata (reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(mask_q & flag_q);
  end
endmodule

// File: rtl/uart_irq_unit_chk.sv
module uart_irq_unit_chk
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LIVE_N-1:0] live_i,
  input logic [EVT_N-1:0]  evt_i,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [SRC_N-1:0]  mask_q,
  input logic [SRC_N-1:0]  flag_q,
  input logic              irq_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic             hit_set, hit_clr, hit_mask, hit_flag;
  logic [SRC_N-1:0] wb;

  assign hit_set  = reg_wr && reg_addr[ADDR_W-1:2] == WORD_W'(OFS_SET >> 2);
  assign hit_clr  = reg_wr && reg_addr[ADDR_W-1:2] == WORD_W'(OFS_CLR >> 2);
  assign hit_mask = reg_wr && reg_addr[ADDR_W-1:2] == WORD_W'(OFS_MASK >> 2);
  assign hit_flag = reg_wr && reg_addr[ADDR_W-1:2] == WORD_W'(OFS_FLAG >> 2);
  assign wb       = reg_wdata[SRC_N-1:0];

  // R2
  live_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q[LIVE_N-1:0] & $past(live_i)) == $past(live_i)));

  // R3
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q[SRC_N-1:LIVE_N] & $past(evt_i)) == $past(evt_i)));

  // R4
  enable_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_set |=> ((mask_q & $past(wb)) == $past(wb)));

  // R5
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |=> ((mask_q & $past(wb)) == '0));

  // R6
  mask_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mask |=> $stable(mask_q));

  // R7
  flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_flag |=> ((flag_q & $past(wb & ~{evt_i, live_i})) == '0));

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(mask_q & flag_q))));
endmodule

bind uart_irq_unit uart_irq_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .live_i    (live_i),
  .evt_i     (evt_i),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .mask_q    (mask_q),
  .flag_q    (flag_q),
  .irq_o     (irq_o)
);

// File: tb/uart_irq_unit_tb.sv
module uart_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  live_i = '0;
  logic [4:0]  evt_i = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  uart_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .live_i(live_i), .evt_i(evt_i),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic clear_all();
    wr(8'h0C, 32'h3FF);
    wr(8'h14, 32'h3FF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h10, v); check("R1 mask", v, 0);
    rd(8'h14, v); check("R1 flags", v, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_live();
    logic [31:0] v;
    clear_all();
    @(negedge clk); live_i = 5'b10110;
    @(negedge clk); live_i = 5'b00000;
    rd(8'h14, v); check("R2 live latched", v, 32'h16);
  endtask

  task automatic t_events();
    logic [31:0] v;
    clear_all();
    @(negedge clk); evt_i = 5'b10101;
    @(negedge clk); evt_i = 5'b00000;
    rd(8'h14, v); check("R3 events latched", v, 32'h2A0);
  endtask

  task automatic t_mask_set_clr();
    logic [31:0] v;
    clear_all();
    wr(8'h08, 32'h0000_0081);
    wr(8'h08, 32'h0000_0300);
    rd(8'h10, v); check("R4 enable ORs", v, 32'h381);
    wr(8'h0C, 32'h0000_0101);
    rd(8'h10, v); check("R5 disable clears", v, 32'h280);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h10, v); check("R10 upper bits zero", v, 32'h3FF);
  endtask

  task automatic t_mask_ro();
    logic [31:0] v;
    clear_all();
    wr(8'h08, 32'h0F);
    wr(8'h10, 32'h3F0);
    rd(8'h10, v); check("R6 mask write ignored", v, 32'h0F);
    wr(8'h2C, 32'h3FF);
    rd(8'h14, v); check("R6 live write ignored", v, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    clear_all();
    @(negedge clk); evt_i = 5'b11111; live_i = 5'b11111;
    @(negedge clk); evt_i = '0; live_i = '0;
    wr(8'h14, 32'h0F0);
    rd(8'h14, v); check("R7 w1c", v, 32'h30F);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    clear_all();
    @(negedge clk); live_i = 5'b00001;
    wr(8'h14, 32'h001);
    rd(8'h14, v); check("R8 live beats clear", v, 32'h001);
    live_i = '0;
    wr(8'h14, 32'h001);
    @(negedge clk);
    reg_addr = 8'h14; reg_wdata = 32'h060; reg_wr = 1'b1; evt_i = 5'b00001;
    @(negedge clk);
    reg_wr = 1'b0; evt_i = '0;
    rd(8'h14, v); check("R8 pulse beats clear", v, 32'h020);
  endtask

  task automatic t_irq();
    clear_all();
    wr(8'h08, 32'h008);
    @(negedge clk); check("R9 irq low idle", {31'b0, irq_o}, 0);
    live_i = 5'b01000;
    @(negedge clk); live_i = '0;
    check("R9 irq one cycle late", {31'b0, irq_o}, 0);
    @(negedge clk); check("R9 irq high", {31'b0, irq_o}, 1);
    wr(8'h0C, 32'h008);
    check("R9 irq lags mask clear", {31'b0, irq_o}, 1);
    @(negedge clk); check("R9 irq low after mask clear", {31'b0, irq_o}, 0);
    wr(8'h08, 32'h008);
    @(negedge clk); check("R9 irq back", {31'b0, irq_o}, 1);
    wr(8'h14, 32'h008);
    @(negedge clk); check("R9 irq low after w1c", {31'b0, irq_o}, 0);
  endtask

  task automatic t_read_map();
    logic [31:0] v;
    @(negedge clk); live_i = 5'b10010;
    rd(8'h2C, v); check("R10 live read", v, 32'h12);
    live_i = '0;
    rd(8'h00, v); check("R10 unmapped zero", v, 0);
    @(negedge clk); check("R10 rdata holds", reg_rdata, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_live();
    t_events();
    t_mask_set_clr();
    t_mask_ro();
    t_w1c();
    t_set_wins();
    t_irq();
    t_read_map();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule